// File: doc/BRIEF.md
# DMA channel interrupt flag unit

This block holds the sticky interrupt flags for every channel of a multi-channel DMA controller. The channel engine sends single-cycle event pulses for each channel: transfer start seen, transfer aborted, cell moved, half of a block moved, block moved, end of the descriptor chain, write bus error and read bus error. Each pulse sets its own flag. The flag stays set until software clears it by writing a one to its bit.

Software reaches the flags through a simple register bus. The bus has a byte address, a write strobe, write data and combinational read data. Each channel's flag word sits at its own address. A read only returns the flags, so software can clear a flag and then read the word back to confirm the clear.

Some events also switch the channel off. A bus error, on either the read or the write side, pulses both a channel-enable clear and a chain-enable clear back to the channel control logic. An abort pulses only the channel-enable clear. Each channel also drives a registered interrupt line. This line is the OR of its flags, each gated by a per-flag enable mask.

Top module: `dma_irq_flags`

## Requirements
- R1: After reset, every channel's flag word reads 0x00000000, and `irq`, `ch_en_clr` and `ll_en_clr` are all low.
- R2: An event pulse on channel k sets that channel's flag. From the next cycle the flag reads as 1 at its bit: start bit 0, abort bit 1, cell done bit 2, block done bit 3, half done bit 4, chain end bit 5, write error bit 17, read error bit 18.
- R3: A bus write to channel k clears each flag whose bit in the write data is 1. Flags whose bit is 0 keep their value.
- R4: If an event and a write-one-to-clear hit the same flag in the same cycle, the flag ends up set.
- R5: A read-error event pulses both `ch_en_clr[k]` and `ll_en_clr[k]` for exactly one cycle. The pulse comes in the same cycle that the read-error flag first reads as 1.
- R6: A write-error event pulses both `ch_en_clr[k]` and `ll_en_clr[k]` for exactly one cycle. The pulse comes in the same cycle that the write-error flag first reads as 1.
- R7: An abort event pulses `ch_en_clr[k]` for one cycle and leaves `ll_en_clr[k]` low.
- R8: Start, cell, half, block and chain-end events drive neither clear output.
- R9: `irq[k]` is a register. It is high in the cycle after a clock edge at which some channel-k flag is set and its enable bit is 1. The enable for flag n of channel k is `irq_en[k*8+n]`, where n follows this order: 0 start, 1 abort, 2 cell, 3 block, 4 half, 5 chain end, 6 write error, 7 read error.
- R10: Channel k's flag word sits at byte address 0x60 + k*0x50. At any other address a read returns 0 and a write changes no flag.
- R11: Unimplemented bits read as 0. Reading a flag word changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low channel reset |
| evt_start | input | NUM_CH | Start-detected pulse per channel |
| evt_abort | input | NUM_CH | Abort pulse per channel |
| evt_cell | input | NUM_CH | Cell-done pulse per channel |
| evt_half | input | NUM_CH | Half-block-done pulse per channel |
| evt_block | input | NUM_CH | Block-done pulse per channel |
| evt_llend | input | NUM_CH | Chain-end pulse per channel |
| evt_wrerr | input | NUM_CH | Write bus error pulse per channel |
| evt_rderr | input | NUM_CH | Read bus error pulse per channel |
| irq_en | input | NUM_CH*8 | Per-flag interrupt enables, 8 per channel |
| reg_addr | input | ADDR_W | Register byte address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data, ones clear flags |
| reg_rdata | output | 32 | Flag word at `reg_addr` |
| ch_en_clr | output | NUM_CH | Channel-enable clear pulse |
| ll_en_clr | output | NUM_CH | Chain-enable clear pulse |
| irq | output | NUM_CH | Registered interrupt per channel |

## Verification
The assertions check the side-effect rules on every cycle. A bus error must drop both enables in the next cycle, and an abort must drop the channel enable. A clear pulse may only follow an event that calls for it. An interrupt may only rise when some enable was set, and reserved read bits must stay zero. The bench scenarios are needed for the parts that span several cycles: the bit position each event lands on, the write-one-to-clear behaviour, and the priority of set over clear in the same cycle. They are also needed for the address map, the handling of unmapped addresses, and the mask-gated interrupt timing for every channel and flag.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

    localparam int unsigned NFLAG  = 8;
    localparam int unsigned WORD_W = 32;

    // compact flag index inside a channel
    localparam int unsigned IDX_START = 0;
    localparam int unsigned IDX_ABORT = 1;
    localparam int unsigned IDX_CELL  = 2;
    localparam int unsigned IDX_BLOCK = 3;
    localparam int unsigned IDX_HALF  = 4;
    localparam int unsigned IDX_LLEND = 5;
    localparam int unsigned IDX_WRERR = 6;
    localparam int unsigned IDX_RDERR = 7;

    typedef struct packed {
        logic [NFLAG-1:0] flags;
        logic             irq;
        logic             ch_off;
        logic             ll_off;
    } chan_state_t;

    // bit position in the software-visible word for each compact index
    function automatic int unsigned word_pos(input int unsigned idx);
        int unsigned p;
        if (idx == IDX_WRERR)      p = 17;
        else if (idx == IDX_RDERR) p = 18;
        else                       p = idx;
        return p;
    endfunction

    function automatic logic [WORD_W-1:0] flags_to_word(input logic [NFLAG-1:0] f);
        logic [WORD_W-1:0] w;
        w = '0;
        for (int unsigned i = 0; i < NFLAG; i++) begin
            w[word_pos(i)] = f[i];
        end
        return w;
    endfunction

    function automatic logic [NFLAG-1:0] word_to_flags(input logic [WORD_W-1:0] w);
        logic [NFLAG-1:0] f;
        for (int unsigned i = 0; i < NFLAG; i++) begin
            f[i] = w[word_pos(i)];
        end
        return f;
    endfunction

    function automatic logic [WORD_W-1:0] impl_mask();
        return flags_to_word({NFLAG{1'b1}});
    endfunction

endpackage

// File: rtl/dma_irq_addr_dec.sv
module dma_irq_addr_dec #(
    parameter int unsigned NUM_CH    = 16,
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned BASE_OFF  = 32'h60,
    parameter int unsigned CH_STRIDE = 32'h50
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_CH-1:0] sel
);

    for (genvar k = 0; k < NUM_CH; k++) begin : g_cmp
        localparam int unsigned CH_ADDR = BASE_OFF + k * CH_STRIDE;
        assign sel[k] = (addr == ADDR_W'(CH_ADDR));
    end

endmodule

// File: rtl/dma_irq_chan.sv
module dma_irq_chan
    import dma_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] evt,
    input  logic [NFLAG-1:0] clr_req,
    input  logic [NFLAG-1:0] en,
    output logic [NFLAG-1:0] flags,
    output logic             irq,
    output logic             ch_off,
    output logic             ll_off
);

    chan_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        // hardware set has priority over a software clear of the same bit
        st_d.flags  = (st_q.flags & ~clr_req) | evt;
        st_d.irq    = |(st_d.flags & en);
        st_d.ch_off = evt[IDX_ABORT] | evt[IDX_RDERR] | evt[IDX_WRERR];
        st_d.ll_off = evt[IDX_RDERR] | evt[IDX_WRERR];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags  = st_q.flags;
    assign irq    = st_q.irq;
    assign ch_off = st_q.ch_off;
    assign ll_off = st_q.ll_off;

endmodule

// File: rtl/dma_irq_rd_mux.sv
module dma_irq_rd_mux
    import dma_irq_pkg::*;
#(
    parameter int unsigned NUM_CH = 16
) (
    input  logic [NUM_CH-1:0]       sel,
    input  logic [NUM_CH*NFLAG-1:0] flags_all,
    output logic [WORD_W-1:0]       rdata
);

    always_comb begin
        rdata = '0;
        for (int unsigned k = 0; k < NUM_CH; k++) begin
            if (sel[k]) begin
                rdata = rdata | flags_to_word(flags_all[k*NFLAG +: NFLAG]);
            end
        end
    end

endmodule

// File: rtl/dma_irq_flags.sv
module dma_irq_flags
    import dma_irq_pkg::*;
#(
    parameter int unsigned NUM_CH    = 16,
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned BASE_OFF  = 32'h60,
    parameter int unsigned CH_STRIDE = 32'h50
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       evt_start,
    input  logic [NUM_CH-1:0]       evt_abort,
    input  logic [NUM_CH-1:0]       evt_cell,
    input  logic [NUM_CH-1:0]       evt_half,
    input  logic [NUM_CH-1:0]       evt_block,
    input  logic [NUM_CH-1:0]       evt_llend,
    input  logic [NUM_CH-1:0]       evt_wrerr,
    input  logic [NUM_CH-1:0]       evt_rderr,
    input  logic [NUM_CH*NFLAG-1:0] irq_en,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic                    reg_we,
    input  logic [WORD_W-1:0]       reg_wdata,
    output logic [WORD_W-1:0]       reg_rdata,
    output logic [NUM_CH-1:0]       ch_en_clr,
    output logic [NUM_CH-1:0]       ll_en_clr,
    output logic [NUM_CH-1:0]       irq
);

    localparam int unsigned FLAT_W = NUM_CH * NFLAG;

    logic [NUM_CH-1:0] sel;
    logic [FLAT_W-1:0] flags_all;
    logic [NFLAG-1:0]  wr_flags;

    assign wr_flags = word_to_flags(reg_wdata);

    dma_irq_addr_dec #(
        .NUM_CH   (NUM_CH),
        .ADDR_W   (ADDR_W),
        .BASE_OFF (BASE_OFF),
        .CH_STRIDE(CH_STRIDE)
    ) u_dec (
        .addr(reg_addr),
        .sel (sel)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
        logic [NFLAG-1:0] evt_k;
        logic [NFLAG-1:0] clr_k;

        always_comb begin
            evt_k            = '0;
            evt_k[IDX_START] = evt_start[k];
            evt_k[IDX_ABORT] = evt_abort[k];
            evt_k[IDX_CELL]  = evt_cell[k];
            evt_k[IDX_BLOCK] = evt_block[k];
            evt_k[IDX_HALF]  = evt_half[k];
            evt_k[IDX_LLEND] = evt_llend[k];
            evt_k[IDX_WRERR] = evt_wrerr[k];
            evt_k[IDX_RDERR] = evt_rderr[k];
            clr_k            = (reg_we && sel[k]) ? wr_flags : '0;
        end

        dma_irq_chan u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt    (evt_k),
            .clr_req(clr_k),
            .en     (irq_en[k*NFLAG +: NFLAG]),
            .flags  (flags_all[k*NFLAG +: NFLAG]),
            .irq    (irq[k]),
            .ch_off (ch_en_clr[k]),
            .ll_off (ll_en_clr[k])
        );
    end

    dma_irq_rd_mux #(
        .NUM_CH(NUM_CH)
    ) u_rd (
        .sel      (sel),
        .flags_all(flags_all),
        .rdata    (reg_rdata)
    );

endmodule

// File: rtl/dma_irq_flags_chk.sv
module dma_irq_flags_chk
    import dma_irq_pkg::*;
#(
    parameter int unsigned NUM_CH = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NUM_CH-1:0]       evt_abort,
    input logic [NUM_CH-1:0]       evt_wrerr,
    input logic [NUM_CH-1:0]       evt_rderr,
    input logic [NUM_CH*NFLAG-1:0] irq_en,
    input logic [WORD_W-1:0]       reg_rdata,
    input logic [NUM_CH-1:0]       ch_en_clr,
    input logic [NUM_CH-1:0]       ll_en_clr,
    input logic [NUM_CH-1:0]       irq
);

    localparam logic [WORD_W-1:0] RSVD = ~impl_mask();

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (reg_rdata & RSVD) == '0); // R11

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        AST_RDERR_DROPS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
            evt_rderr[k] |=> (ch_en_clr[k] && ll_en_clr[k])); // R5
        AST_WRERR_DROPS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
            evt_wrerr[k] |=> (ch_en_clr[k] && ll_en_clr[k])); // R6
        AST_ABORT_DROPS_CH: assert property (@(posedge clk) disable iff (!rst_n)
            evt_abort[k] |=> ch_en_clr[k]); // R7
        AST_LL_CLR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            ll_en_clr[k] |-> $past(evt_rderr[k] || evt_wrerr[k])); // R8
        AST_CH_CLR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            ch_en_clr[k] |-> $past(evt_rderr[k] || evt_wrerr[k] || evt_abort[k])); // R8
        AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
            irq[k] |-> $past(|irq_en[k*NFLAG +: NFLAG])); // R9
    end

endmodule

bind dma_irq_flags dma_irq_flags_chk #(
    .NUM_CH(NUM_CH)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_abort(evt_abort),
    .evt_wrerr(evt_wrerr),
    .evt_rderr(evt_rderr),
    .irq_en   (irq_en),
    .reg_rdata(reg_rdata),
    .ch_en_clr(ch_en_clr),
    .ll_en_clr(ll_en_clr),
    .irq      (irq)
);

// File: tb/tb_dma_irq_flags.sv
`timescale 1ns/1ps
module tb_dma_irq_flags;

    localparam int NUM_CH = 16;
    localparam int ADDR_W = 12;
    localparam int NF     = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NUM_CH-1:0]    ev [NF];
    logic [NUM_CH*NF-1:0] irq_en = '0;
    logic [ADDR_W-1:0]    reg_addr = '0;
    logic                 reg_we = 1'b0;
    logic [31:0]          reg_wdata = '0;
    logic [31:0]          reg_rdata;
    logic [NUM_CH-1:0]    ch_en_clr, ll_en_clr, irq;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    always #2.5 clk = ~clk;

    dma_irq_flags #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .evt_start(ev[0]), .evt_abort(ev[1]), .evt_cell(ev[2]), .evt_block(ev[3]),
        .evt_half(ev[4]), .evt_llend(ev[5]), .evt_wrerr(ev[6]), .evt_rderr(ev[7]),
        .irq_en(irq_en), .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ch_en_clr(ch_en_clr), .ll_en_clr(ll_en_clr), .irq(irq)
    );

    function automatic int bitpos(input int i);
        return (i == 6) ? 17 : (i == 7) ? 18 : i;
    endfunction

    function automatic logic [ADDR_W-1:0] chaddr(input int k);
        return ADDR_W'(32'h60 + k * 32'h50);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic pulse(input int k, input int i);
        @(negedge clk);
        ev[i][k] = 1'b1;
        @(negedge clk);
        ev[i][k] = 1'b0;
    endtask

    task automatic summary;
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NF; i++) ev[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 ch_en_clr", 32'(ch_en_clr), 32'h0);
        chk("R1 ll_en_clr", 32'(ll_en_clr), 32'h0);
        for (int k = 0; k < NUM_CH; k++) begin
            reg_addr = chaddr(k); #0.1;
            chk("R1 word", reg_rdata, 32'h0);
        end

        // sweep every channel and every flag
        for (int k = 0; k < NUM_CH; k++) begin
            for (int i = 0; i < NF; i++) begin
                logic [31:0] w;
                logic ech, ell;
                w   = 32'h1 << bitpos(i);
                ech = (i == 1) || (i == 6) || (i == 7);
                ell = (i == 6) || (i == 7);
                irq_en   = '0;
                reg_addr = chaddr(k);
                pulse(k, i);
                chk("R2 set position", reg_rdata, w);
                if (i == 7)      chk("R5 rderr clears", {30'h0, ch_en_clr[k], ll_en_clr[k]}, 32'h3);
                else if (i == 6) chk("R6 wrerr clears", {30'h0, ch_en_clr[k], ll_en_clr[k]}, 32'h3);
                else if (i == 1) chk("R7 abort clears", {30'h0, ch_en_clr[k], ll_en_clr[k]}, 32'h2);
                else             chk("R8 no clears", {30'h0, ch_en_clr[k], ll_en_clr[k]}, 32'h0);
                chk("R9 masked irq low", 32'(irq[k]), 32'h0);
                @(negedge clk);
                chk("R5 R6 R7 single-cycle pulse", {30'h0, ch_en_clr[k], ll_en_clr[k]}, 32'h0);
                if (ech) chk("R8 pulse only after own event", 32'(ll_en_clr[k]), 32'h0);
                irq_en[k*NF + i] = 1'b1;
                @(negedge clk);
                chk("R9 irq with enable", 32'(irq), 32'h1 << k);
                chk("R11 read has no side effect", reg_rdata, w);
                wr(chaddr(k), ~w);
                chk("R3 zero bit keeps flag", reg_rdata, w);
                wr(chaddr(k), w);
                chk("R3 one bit clears flag", reg_rdata, 32'h0);
                chk("R9 irq drops after clear", 32'(irq[k]), 32'h0);
                if (ell) chk("R5 R6 ll pulse gone", 32'(ll_en_clr), 32'h0);
            end
        end
        irq_en = '0;

        // R4: set wins over clear in the same cycle, other bit still clears
        pulse(3, 0);
        @(negedge clk);
        reg_addr = chaddr(3); reg_wdata = 32'h5; reg_we = 1'b1; ev[2][3] = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; ev[2][3] = 1'b0;
        chk("R4 set wins", reg_rdata, 32'h4);
        wr(chaddr(3), 32'h4);
        chk("R4 later clear", reg_rdata, 32'h0);

        // R10: unmapped addresses
        pulse(5, 3);
        wr(chaddr(5) + 4, 32'hFFFF_FFFF);
        reg_addr = chaddr(5); #0.1;
        chk("R10 unmapped write ignored", reg_rdata, 32'h8);
        reg_addr = chaddr(5) + 4; #0.1;
        chk("R10 unmapped read zero", reg_rdata, 32'h0);
        reg_addr = '0; #0.1;
        chk("R10 address zero reads zero", reg_rdata, 32'h0);
        wr(chaddr(6), 32'hFFFF_FFFF);
        reg_addr = chaddr(5); #0.1;
        chk("R10 neighbour write ignored", reg_rdata, 32'h8);
        wr(chaddr(5), 32'h8);
        chk("R10 own write clears", reg_rdata, 32'h0);

        // R11: all events at once, reserved bits zero
        @(negedge clk);
        for (int i = 0; i < NF; i++) ev[i][15] = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NF; i++) ev[i][15] = 1'b0;
        reg_addr = chaddr(15); #0.1;
        chk("R11 full word", reg_rdata, 32'h0006_003F);
        chk("R5 combined clears", {30'h0, ch_en_clr[15], ll_en_clr[15]}, 32'h3);
        @(negedge clk);
        chk("R11 reread unchanged", reg_rdata, 32'h0006_003F);
        wr(chaddr(15), 32'hFFFF_FFFF);
        chk("R3 clear all", reg_rdata, 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule